// File: doc/BRIEF.md
# Floating-point vector minimum reduction

This unit decodes one SIMD reduction instruction and executes it in the same pass. It looks at a 32-bit instruction word, finds out whether the word is one of the two legal forms of the "minimum across vector" operation, and, if so, reduces the lanes of the source vector to the smallest floating-point value. The result is a scalar of element width, zero-extended to 32 bits. Half-precision lanes are 16 bits wide: four lanes cover the low 64 bits, or eight lanes cover all 128. Single-precision lanes are four 32-bit lanes over 128 bits.

The lanes are reduced through a fixed tree of two-input minimum steps. Adjacent lanes are paired first, then adjacent results, until one value remains. Because the tree shape is fixed, NaN results are deterministic. A mode input selects between two NaN and zero policies.

The unit reports two exception flags for each instruction: invalid operation and input denormal. These flags are meant to be ORed into a sticky status register. The unit also reports an undefined-instruction flag, and it passes through the register index fields. All outputs are registered and appear one clock after the inputs.

Top module: `fp_vmin_reduce`

## Requirements
- R1: One clock after the inputs, result_o holds the minimum of the selected lanes, taken through a pairwise tree (lane 2i is the first operand against lane 2i+1, then the same at each higher level). A half result sits in bits 15..0 with bits 31..16 zero. rd_o holds instr bits 4..0 and rn_o holds instr bits 9..5. During reset, every output is zero.
- R2: The half class is bit 31 = 0 and bits 29..10 = 00111010110000111110, with Q = bit 30. Q=0 reduces four lanes from vec bits 63..0 and ignores vec bits 127..64. Q=1 reduces eight lanes. Lane k is vec[16k+15:16k].
- R3: When fp16_en_i is 0, a half-class word is undefined.
- R4: The single class is bit 31 = 0, bit 29 = 1, bits 28..23 = 011101 and bits 21..10 = 110000111110, with sz = bit 22 and Q = bit 30. Only sz=0 with Q=1 is legal. It reduces four lanes, and lane k is vec[32k+31:32k]. Every other sz:Q value in this class is undefined.
- R5: A word that matches neither class is undefined. When undef_o is 1, result_o, invalid_o and denorm_o are 0.
- R6: With alt_mode_i=0, a step that has a signalling NaN operand returns the default NaN: 0x7E00 for half, 0x7FC00000 for single. A signalling NaN has all exponent bits set, a nonzero mantissa, and the top mantissa bit clear.
- R7: With alt_mode_i=0 and no signalling NaN in a step, the step returns the first operand if it is a NaN. Otherwise, if the second operand is a NaN, the step returns the second operand. The NaN passes through unchanged.
- R8: With alt_mode_i=0, non-NaN values are ordered numerically and negative zero is below positive zero. Infinities order as the extremes. Subnormals order by their value and are not flushed.
- R9: With alt_mode_i=1, a step returns its second operand when either operand is any NaN or both operands are zeros. Otherwise the step returns the smaller operand.
- R10: For a defined word, invalid_o is 1 exactly when a selected lane is a signalling NaN. This holds in both modes.
- R11: For a defined word, denorm_o is 1 exactly when a selected lane is subnormal (zero exponent, nonzero mantissa).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word |
| vec_i | input | 128 | Source vector |
| alt_mode_i | input | 1 | Alternate NaN/zero handling select |
| fp16_en_i | input | 1 | Half-precision forms enabled |
| result_o | output | 32 | Scalar minimum, zero-extended |
| rd_o | output | 5 | Destination register index |
| rn_o | output | 5 | Source register index |
| undef_o | output | 1 | Word is not a legal form of the operation |
| invalid_o | output | 1 | Invalid-operation exception |
| denorm_o | output | 1 | Input-denormal exception |

## Verification
The assertions check several properties on every cycle:
- an undefined word produces a zero result and no flags;
- a half result never has upper bits set;
- the half forms never decode while half precision is disabled;
- in the default mode the result is never a signalling NaN;
- an invalid flag in the default mode always comes with a NaN result.

The bench scenarios show the remaining behaviour. These cover the numeric value of the minimum, the tree pairing order for NaNs and for mixed-sign zeros in both modes, and the lane selection for each width. They also cover which sz:Q values are rejected and the exact conditions for each flag.

// File: rtl/fp_vmin_pkg.sv
package fp_vmin_pkg;

  localparam int VEC_W   = 128;
  localparam int HALF_W  = 16;
  localparam int SGL_W   = 32;
  localparam int LANES   = VEC_W / HALF_W;
  localparam int LEVELS  = $clog2(LANES);
  localparam int REG_W   = 5;

  typedef enum logic [1:0] {
    SHP_NONE = 2'd0,
    SHP_H4   = 2'd1,
    SHP_H8   = 2'd2,
    SHP_S4   = 2'd3
  } shape_e;

  function automatic logic fp_is_nan(input logic [31:0] x, input logic h);
    if (h) return (&x[14:10]) && (|x[9:0]);
    return (&x[30:23]) && (|x[22:0]);
  endfunction

  function automatic logic fp_quiet_bit(input logic [31:0] x, input logic h);
    return h ? x[9] : x[22];
  endfunction

  function automatic logic fp_is_snan(input logic [31:0] x, input logic h);
    return fp_is_nan(x, h) && !fp_quiet_bit(x, h);
  endfunction

  function automatic logic fp_is_zero(input logic [31:0] x, input logic h);
    return h ? ~|x[14:0] : ~|x[30:0];
  endfunction

  function automatic logic fp_is_sub(input logic [31:0] x, input logic h);
    if (h) return (~|x[14:10]) && (|x[9:0]);
    return (~|x[30:23]) && (|x[22:0]);
  endfunction

  function automatic logic [31:0] fp_dnan(input logic h);
    return h ? 32'h0000_7E00 : 32'h7FC0_0000;
  endfunction

  // a strictly below b for non-NaN operands; -0 sits below +0
  function automatic logic fp_below(input logic [31:0] a, input logic [31:0] b,
                                    input logic h);
    logic        sa, sb;
    logic [30:0] ma, mb;
    sa = h ? a[15] : a[31];
    sb = h ? b[15] : b[31];
    ma = h ? {16'b0, a[14:0]} : a[30:0];
    mb = h ? {16'b0, b[14:0]} : b[30:0];
    if (sa != sb) return sa;
    if (!sa) return ma < mb;
    return ma > mb;
  endfunction

  function automatic logic [31:0] fp_min_step(input logic [31:0] a, input logic [31:0] b,
                                              input logic h, input logic alt);
    logic na, nb;
    na = fp_is_nan(a, h);
    nb = fp_is_nan(b, h);
    if (alt) begin
      if (na || nb || (fp_is_zero(a, h) && fp_is_zero(b, h))) return b;
    end else begin
      if (fp_is_snan(a, h) || fp_is_snan(b, h)) return fp_dnan(h);
      if (na) return a;
      if (nb) return b;
    end
    return fp_below(b, a, h) ? b : a;
  endfunction

endpackage

// File: rtl/fp_vmin_decode.sv
module fp_vmin_decode
  import fp_vmin_pkg::*;
(
  input  logic [31:0]      instr_i,
  input  logic             fp16_en_i,
  output shape_e           shape_o,
  output logic             undef_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rn_o
);

  logic fld_q, fld_sz;
  logic half_hit, sgl_hit, tail_ok;

  assign fld_q   = instr_i[30];
  assign fld_sz  = instr_i[22];
  // bits shared by both classes
  assign tail_ok = (instr_i[31] == 1'b0) && (instr_i[28:23] == 6'b011101) &&
                   (instr_i[21:10] == 12'b110000111110);
  assign half_hit = tail_ok && (instr_i[29] == 1'b0) && (fld_sz == 1'b0);
  assign sgl_hit  = tail_ok && (instr_i[29] == 1'b1);

  always_comb begin
    shape_o = SHP_NONE;
    if (half_hit) begin
      if (fp16_en_i) shape_o = fld_q ? SHP_H8 : SHP_H4;
    end else if (sgl_hit) begin
      if (!fld_sz && fld_q) shape_o = SHP_S4;
    end
  end

  assign undef_o = (shape_o == SHP_NONE);
  assign rd_o    = instr_i[4:0];
  assign rn_o    = instr_i[9:5];

endmodule

// File: rtl/fp_vmin_lanes.sv
module fp_vmin_lanes
  import fp_vmin_pkg::*;
(
  input  logic [VEC_W-1:0] vec_i,
  input  shape_e           shape_i,
  output logic [31:0]      lane_o [LANES],
  output logic             is_half_o,
  output logic             snan_any_o,
  output logic             sub_any_o
);

  localparam int HALF_LANES = LANES / 2;

  logic [LANES-1:0] used, snan_k, sub_k;

  assign is_half_o = (shape_i == SHP_H4) || (shape_i == SHP_H8);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [31:0] hv, sv;
    assign hv = {16'b0, vec_i[HALF_W*k +: HALF_W]};
    if (k < HALF_LANES) begin : g_low
      assign sv      = vec_i[SGL_W*k +: SGL_W];
      assign used[k] = (shape_i != SHP_NONE);
    end else begin : g_high
      assign sv      = '0;
      assign used[k] = (shape_i == SHP_H8);
    end
    assign lane_o[k] = (shape_i == SHP_S4) ? sv : hv;
    assign snan_k[k] = used[k] && fp_is_snan(lane_o[k], is_half_o);
    assign sub_k[k]  = used[k] && fp_is_sub(lane_o[k], is_half_o);
  end

  assign snan_any_o = |snan_k;
  assign sub_any_o  = |sub_k;

endmodule

// File: rtl/fp_vmin_tree.sv
module fp_vmin_tree
  import fp_vmin_pkg::*;
(
  input  logic [31:0] lane_i [LANES],
  input  logic        is_half_i,
  input  logic        alt_i,
  output logic [31:0] root_o,
  output logic [31:0] low_half_o
);

  for (genvar lv = 0; lv <= LEVELS; lv++) begin : g_lvl
    localparam int CNT = LANES >> lv;
    logic [31:0] v [CNT];
    if (lv == 0) begin : g_leaf
      for (genvar j = 0; j < CNT; j++) begin : g_j
        assign v[j] = lane_i[j];
      end
    end else begin : g_node
      for (genvar j = 0; j < CNT; j++) begin : g_j
        assign v[j] = fp_min_step(g_lvl[lv-1].v[2*j], g_lvl[lv-1].v[2*j+1],
                                  is_half_i, alt_i);
      end
    end
  end

  assign root_o     = g_lvl[LEVELS].v[0];
  assign low_half_o = g_lvl[LEVELS-1].v[0];

endmodule

// File: rtl/fp_vmin_reduce.sv
module fp_vmin_reduce
  import fp_vmin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [31:0]      instr_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             alt_mode_i,
  input  logic             fp16_en_i,
  output logic [31:0]      result_o,
  output logic [REG_W-1:0] rd_o,
  output logic [REG_W-1:0] rn_o,
  output logic             undef_o,
  output logic             invalid_o,
  output logic             denorm_o
);

  shape_e           shape;
  logic             dec_undef, is_half, snan_any, sub_any;
  logic [REG_W-1:0] dec_rd, dec_rn;
  logic [31:0]      lanes [LANES];
  logic [31:0]      tree_root, tree_low, pick;

  fp_vmin_decode u_dec (
    .instr_i  (instr_i),
    .fp16_en_i(fp16_en_i),
    .shape_o  (shape),
    .undef_o  (dec_undef),
    .rd_o     (dec_rd),
    .rn_o     (dec_rn)
  );

  fp_vmin_lanes u_lanes (
    .vec_i     (vec_i),
    .shape_i   (shape),
    .lane_o    (lanes),
    .is_half_o (is_half),
    .snan_any_o(snan_any),
    .sub_any_o (sub_any)
  );

  fp_vmin_tree u_tree (
    .lane_i    (lanes),
    .is_half_i (is_half),
    .alt_i     (alt_mode_i),
    .root_o    (tree_root),
    .low_half_o(tree_low)
  );

  always_comb begin
    unique case (shape)
      SHP_H8:         pick = tree_root;
      SHP_H4, SHP_S4: pick = tree_low;
      default:        pick = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      result_o  <= '0;
      rd_o      <= '0;
      rn_o      <= '0;
      undef_o   <= 1'b0;
      invalid_o <= 1'b0;
      denorm_o  <= 1'b0;
    end else begin
      result_o  <= pick;
      rd_o      <= dec_rd;
      rn_o      <= dec_rn;
      undef_o   <= dec_undef;
      invalid_o <= snan_any;
      denorm_o  <= sub_any;
    end
  end

  // R5: an undefined word leaves a zero result and no flags
  a_r5_undef_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    undef_o |-> (result_o == 32'h0 && !invalid_o && !denorm_o));

  // R3: half forms never decode while half precision is disabled
  a_r3_fp16_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fp16_en_i |-> (shape != SHP_H4 && shape != SHP_H8));

  // R1: half results are zero-extended
  a_r1_half_zext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(is_half) |-> (result_o[31:16] == 16'h0));

  // R6: default mode never emits a signalling NaN
  a_r6_alt0_quiet_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(alt_mode_i) && !undef_o && fp_is_nan(result_o, $past(is_half)))
      |-> fp_quiet_bit(result_o, $past(is_half)));

  // R10: invalid in default mode always comes with a NaN result
  a_r10_inv_nan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (invalid_o && !$past(alt_mode_i)) |-> fp_is_nan(result_o, $past(is_half)));

endmodule

// File: tb/fp_vmin_reduce_tb_top.sv
module fp_vmin_reduce_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] vec = '0;
  logic         alt = 1'b0;
  logic         fp16 = 1'b1;
  logic [31:0]  result;
  logic [4:0]   rd, rn;
  logic         undef, inv, den;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #2.5ns clk = ~clk;

  fp_vmin_reduce dut_i (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .vec_i(vec),
    .alt_mode_i(alt), .fp16_en_i(fp16), .result_o(result), .rd_o(rd),
    .rn_o(rn), .undef_o(undef), .invalid_o(inv), .denorm_o(den)
  );

  // ---------------- behavioural model ----------------
  function automatic bit m_nan(logic [31:0] x, bit h);
    if (h) return x[14:10] == 5'h1f && x[9:0] != 0;
    return x[30:23] == 8'hff && x[22:0] != 0;
  endfunction
  function automatic bit m_snan(logic [31:0] x, bit h);
    return m_nan(x, h) && !(h ? x[9] : x[22]);
  endfunction
  function automatic bit m_zero(logic [31:0] x, bit h);
    return h ? (x[14:0] == 0) : (x[30:0] == 0);
  endfunction
  function automatic bit m_sub(logic [31:0] x, bit h);
    if (h) return x[14:10] == 0 && x[9:0] != 0;
    return x[30:23] == 0 && x[22:0] != 0;
  endfunction
  // monotone unsigned key for non-NaN values
  function automatic logic [31:0] m_key(logic [31:0] x, bit h);
    if (h) return x[15] ? {16'h0, ~x[15:0]} : {16'h0, x[15:0] | 16'h8000};
    return x[31] ? ~x : (x | 32'h8000_0000);
  endfunction
  function automatic logic [31:0] m_step(logic [31:0] a, logic [31:0] b, bit h, bit am);
    if (am) begin
      if (m_nan(a, h) || m_nan(b, h) || (m_zero(a, h) && m_zero(b, h))) return b;
    end else begin
      if (m_snan(a, h) || m_snan(b, h)) return h ? 32'h7E00 : 32'h7FC0_0000;
      if (m_nan(a, h)) return a;
      if (m_nan(b, h)) return b;
    end
    return (m_key(b, h) < m_key(a, h)) ? b : a;
  endfunction

  task automatic model(input logic [31:0] iw, input logic [127:0] v, input bit am,
                       input bit f16, output logic [31:0] r, output bit e_inv,
                       output bit e_den, output bit e_und);
    logic [31:0] w [8];
    int  n;
    bit  h;
    bit  hm = ((iw & 32'hBFFF_FC00) == 32'h0EB0_F800);
    bit  sm = ((iw & 32'hBFBF_FC00) == 32'h2EB0_F800);
    r = 0; e_inv = 0; e_den = 0;
    if (hm && f16) begin
      h = 1; n = iw[30] ? 8 : 4;
      for (int k = 0; k < 8; k++) w[k] = {16'h0, v[16*k +: 16]};
    end else if (sm && iw[30] && !iw[22]) begin
      h = 0; n = 4;
      for (int k = 0; k < 8; k++) w[k] = (k < 4) ? v[32*k +: 32] : 32'h0;
    end else begin
      e_und = 1; return;
    end
    e_und = 0;
    for (int k = 0; k < n; k++) begin
      if (m_snan(w[k], h)) e_inv = 1;
      if (m_sub(w[k], h)) e_den = 1;
    end
    while (n > 1) begin
      for (int i = 0; i < n / 2; i++) w[i] = m_step(w[2*i], w[2*i+1], h, am);
      n = n / 2;
    end
    r = w[0];
  endtask

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] t = s;
    t ^= t << 13; t ^= t >> 17; t ^= t << 5;
    return t;
  endfunction
  function automatic logic [15:0] sp16(int i);
    case (i % 16)
      0: return 16'h0000;  1: return 16'h8000;  2: return 16'h3C00;  3: return 16'hBC00;
      4: return 16'h7C00;  5: return 16'hFC00;  6: return 16'h0001;  7: return 16'h8001;
      8: return 16'h03FF;  9: return 16'h7BFF; 10: return 16'hFBFF; 11: return 16'h7E00;
      12: return 16'h7C01; 13: return 16'hFD00; 14: return 16'h7E01; default: return 16'h4000;
    endcase
  endfunction
  function automatic logic [31:0] sp32(int i);
    case (i % 16)
      0: return 32'h0000_0000;  1: return 32'h8000_0000;  2: return 32'h3F80_0000;
      3: return 32'hBF80_0000;  4: return 32'h7F80_0000;  5: return 32'hFF80_0000;
      6: return 32'h0000_0001;  7: return 32'h8000_0001;  8: return 32'h007F_FFFF;
      9: return 32'h7F7F_FFFF; 10: return 32'hFF7F_FFFF; 11: return 32'h7FC0_0000;
      12: return 32'h7F80_0001; 13: return 32'hFFA0_0000; 14: return 32'h7FC1_2345;
      default: return 32'h4000_0000;
    endcase
  endfunction
  function automatic logic [31:0] i_half(bit q, logic [4:0] n, logic [4:0] d);
    return 32'h0EB0_F800 | (32'(q) << 30) | (32'(n) << 5) | 32'(d);
  endfunction
  function automatic logic [31:0] i_sgl(bit q, bit sz, logic [4:0] n, logic [4:0] d);
    return 32'h2EB0_F800 | (32'(q) << 30) | (32'(sz) << 22) | (32'(n) << 5) | 32'(d);
  endfunction

  task automatic check(input string tag, input logic [31:0] er, input bit ei,
                       input bit ed, input bit eu, input logic [4:0] erd,
                       input logic [4:0] ern);
    n_checks++;
    if (result !== er || inv !== ei || den !== ed || undef !== eu ||
        rd !== erd || rn !== ern) begin
      n_errors++;
      $display("FAIL %s: got res=%h inv=%b den=%b und=%b rd=%0d rn=%0d exp res=%h inv=%b den=%b und=%b rd=%0d rn=%0d",
               tag, result, inv, den, undef, rd, rn, er, ei, ed, eu, erd, ern);
    end
  endtask

  task automatic run(input string tag, input logic [31:0] iw, input logic [127:0] v,
                     input bit am, input bit f16);
    logic [31:0] er; bit ei, ed, eu;
    instr = iw; vec = v; alt = am; fp16 = f16;
    @(posedge clk); @(negedge clk);
    model(iw, v, am, f16, er, ei, ed, eu);
    check(tag, er, ei, ed, eu, iw[4:0], iw[9:5]);
  endtask

  task automatic run_lit(input string tag, input logic [31:0] iw, input logic [127:0] v,
                         input bit am, input logic [31:0] er, input bit ei);
    instr = iw; vec = v; alt = am; fp16 = 1;
    @(posedge clk); @(negedge clk);
    check(tag, er, ei, 1'b0, 1'b0, iw[4:0], iw[9:5]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] v;
    instr = i_half(1, 5'd3, 5'd7);
    vec = {8{16'h3C00}};
    repeat (3) @(negedge clk);
    check("R1 reset", 32'h0, 0, 0, 0, 5'd0, 5'd0);
    @(negedge clk) rst_n = 1;

    // R1 basic ordering and index fields
    run_lit("R1 basic", i_half(0, 5'd9, 5'd17),
            {64'h0, 16'h4000, 16'hBC00, 16'h3C00, 16'h4400}, 0, 32'h0000_BC00, 0);
    // R2 four lanes ignore upper half of vector
    run_lit("R2 q0", i_half(0, 5'd1, 5'd2),
            {64'hFC00_FC00_FC00_FC00, 16'h3C00, 16'h4000, 16'h4400, 16'h4200}, 0,
            32'h0000_3C00, 0);
    run_lit("R2 q1", i_half(1, 5'd1, 5'd2),
            {64'hFC00_FC00_FC00_FC00, 16'h3C00, 16'h4000, 16'h4400, 16'h4200}, 0,
            32'h0000_FC00, 0);
    // R3 half disabled
    run("R3 fp16 off q0", i_half(0, 5'd4, 5'd5), {8{16'h3C00}}, 0, 0);
    run("R3 fp16 off q1", i_half(1, 5'd4, 5'd5), {8{16'h7C01}}, 0, 0);
    // R4 single: legal and the three illegal sz:Q values
    run_lit("R4 legal", i_sgl(1, 0, 5'd6, 5'd8),
            {32'h4000_0000, 32'hBF80_0000, 32'h3F80_0000, 32'h7F80_0000}, 0, 32'hBF80_0000, 0);
    run("R4 sz0 q0", i_sgl(0, 0, 5'd6, 5'd8), {4{32'h3F80_0000}}, 0, 1);
    run("R4 sz1 q0", i_sgl(0, 1, 5'd6, 5'd8), {4{32'h3F80_0000}}, 0, 1);
    run("R4 sz1 q1", i_sgl(1, 1, 5'd6, 5'd8), {4{32'h7F80_0001}}, 0, 1);
    // R5 unrelated word and half with bit 22 set
    run("R5 other", 32'h1E20_4000, {8{16'h0001}}, 0, 1);
    run("R5 half bit22", i_half(1, 5'd0, 5'd0) | 32'h0040_0000, {8{16'h7C01}}, 0, 1);
    // R6 signalling NaN gives default NaN
    run_lit("R6 half snan", i_half(0, 5'd0, 5'd1),
            {64'h0, 16'h3C00, 16'h7E05, 16'h3C00, 16'h7C01}, 0, 32'h0000_7E00, 1);
    run_lit("R6 sgl snan", i_sgl(1, 0, 5'd0, 5'd1),
            {32'h0, 32'hFFA0_0000, 32'h3F80_0000, 32'h0}, 0, 32'h7FC0_0000, 1);
    // R7 first NaN operand wins, payload kept
    run_lit("R7 first nan", i_half(0, 5'd0, 5'd1),
            {64'h0, 16'h3C00, 16'h3C00, 16'h7E00, 16'h7E01}, 0, 32'h0000_7E01, 0);
    run_lit("R7 second nan", i_half(0, 5'd0, 5'd1),
            {64'h0, 16'h3C00, 16'h3C00, 16'h7E05, 16'h4000}, 0, 32'h0000_7E05, 0);
    // R8 signed zeros, infinity, subnormal
    run_lit("R8 zeros", i_half(0, 5'd0, 5'd1),
            {64'h0, 16'h0000, 16'h0000, 16'h8000, 16'h0000}, 0, 32'h0000_8000, 0);
    run_lit("R8 inf", i_sgl(1, 0, 5'd0, 5'd1),
            {32'hFF7F_FFFF, 32'hFF80_0000, 32'h7F80_0000, 32'h0}, 0, 32'hFF80_0000, 0);
    // R9 alternate mode: second operand on NaN or both zero
    run_lit("R9 nan first", i_half(0, 5'd0, 5'd1),
            {64'h0, 16'h4000, 16'h4000, 16'h3C00, 16'h7E00}, 1, 32'h0000_3C00, 0);
    run_lit("R9 zeros", i_half(0, 5'd0, 5'd1),
            {64'h0, 16'h0000, 16'h8000, 16'h8000, 16'h0000}, 1, 32'h0000_0000, 0);
    run_lit("R9 all nan", i_half(1, 5'd0, 5'd1),
            {16'h7E07, 16'h7E06, 16'h7E05, 16'h7E04, 16'h7E03, 16'h7E02, 16'h7E01, 16'h7E00},
            1, 32'h0000_7E07, 0);
    run_lit("R7 all nan", i_half(1, 5'd0, 5'd1),
            {16'h7E07, 16'h7E06, 16'h7E05, 16'h7E04, 16'h7E03, 16'h7E02, 16'h7E01, 16'h7E00},
            0, 32'h0000_7E00, 0);
    // R10 signalling NaN in alternate mode still flags; upper lanes of q0 do not
    run_lit("R10 alt snan", i_half(0, 5'd0, 5'd1),
            {64'h0, 16'h3C00, 16'h3C00, 16'h3C00, 16'h7C01}, 1, 32'h0000_3C00, 1);
    run_lit("R10 unused snan", i_half(0, 5'd0, 5'd1),
            {64'h7C01_7C01_7C01_7C01, 16'h3C00, 16'h3C00, 16'h3C00, 16'h4000}, 0, 32'h0000_3C00, 0);
    // R11 subnormal flag, selected lanes only
    run("R11 den", i_half(0, 5'd0, 5'd1), {64'h0, 16'h0001, 16'h3C00, 16'h3C00, 16'h3C00}, 0, 1);
    run("R11 unused den", i_half(0, 5'd0, 5'd1), {64'h0001_0001_0001_0001, 64'h3C00_3C00_3C00_3C00}, 0, 1);
    run("R11 sgl den", i_sgl(1, 0, 5'd0, 5'd1), {32'h007F_FFFF, 96'h0}, 1, 1);

    // pairwise sweep over half specials, both modes (R6 R7 R8 R9)
    for (int am = 0; am < 2; am++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          seed = nxt(seed);
          v = {seed, ~seed, sp16(j + 5), sp16(i + 3), sp16(j), sp16(i)};
          run("R8 R9 pair sweep", i_half(0, seed[9:5], seed[4:0]), v, am[0], 1);
        end

    // mixed vectors in every legal shape (R1 R2 R4 R10 R11)
    for (int t = 0; t < 900; t++) begin
      for (int k = 0; k < 8; k++) begin
        seed = nxt(seed);
        if (t < 600) v[16*k +: 16] = seed[1:0] != 0 ? sp16(int'(seed[7:4])) : seed[31:16];
        else if (k < 4) v[32*k +: 32] = seed[1:0] != 0 ? sp32(int'(seed[7:4])) : nxt(seed);
      end
      seed = nxt(seed);
      if (t < 300)      run("R2 h8 mix", i_half(1, seed[9:5], seed[4:0]), v, seed[12], 1);
      else if (t < 600) run("R2 h4 mix", i_half(0, seed[9:5], seed[4:0]), v, seed[12], 1);
      else              run("R4 s4 mix", i_sgl(1, 0, seed[9:5], seed[4:0]), v, seed[12], 1);
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule